// File: doc/BRIEF.md
# Serial Flag-Offset Register Loader

This block fills the four threshold registers that a pair of FIFOs uses to raise almost-empty and almost-full warnings. Two registers serve the first FIFO (`ofs_y1` for almost-full, `ofs_x1` for almost-empty) and two serve the second (`ofs_y2`, `ofs_x2`). A three-bit method code is held steady while master reset is asserted. The block captures that code, and it chooses how the registers get their contents once reset is released.

There are three ways to load the registers. A fixed preset writes the same power-of-two value into all four registers. Parallel loading takes four words from the write port, in a fixed order. Serial loading shifts in one continuous bit stream through a low-active enable, on the same clock as the write port. The `prog_done` output tells the flag logic that the thresholds are valid. After that, no loading input can change them until the next master reset.

The register width `OFS_W` equals log2 of the FIFO depth: 11, 12 or 13 for 2K, 4K or 8K words. A full serial stream is therefore 44, 48 or 52 bits long.

Top module: `flag_offset_loader`

## Requirements
- R1: On every clock edge where `mrst_n` is 0, all four offset outputs become 0 and `prog_done` becomes 0. This also applies when reset arrives in the middle of a load.
- R2: The method code is the value of `method_sel` at the last clock edge with `mrst_n` at 0. Changing `method_sel` while `mrst_n` is 1 has no effect on the method.
- R3: Codes 0, 1, 2, 3 and 4 select the presets 8, 16, 64, 256 and 1024. After the first clock edge with `mrst_n` at 1, all four outputs show the selected preset and `prog_done` is 1.
- R4: Code 5 selects parallel loading. The first four clock edges with `wr_en` at 1 store `wr_data` into Y1, X1, Y2 and X2, in that order. Registers not yet written read 0. `prog_done` rises at the edge of the fourth write.
- R5: Codes 6 and 7 select serial loading. At each clock edge with `ser_en_n` at 0, the concatenation {Y1,X1,Y2,X2} shifts left by one bit, and `ser_bit` enters at the LSB of X2. At edges with `ser_en_n` at 1, nothing changes. As a result, the first bit ends up as the MSB of Y1 and the last bit as the LSB of X2.
- R6: In serial mode, `prog_done` stays 0 through the first 4*OFS_W-1 accepted bits. It becomes 1 at the edge that accepts bit number 4*OFS_W. Once `prog_done` is 1, it stays 1 until the next master reset.
- R7: After `prog_done` is 1, further serial bits and further writes leave all four offsets unchanged.
- R8: Each method ignores the inputs of the other method. In serial mode, `wr_en` pulses change nothing. In parallel mode, `ser_en_n` pulses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock; all state changes on its rising edge |
| mrst_n | input | 1 | Synchronous master reset, active low |
| method_sel | input | 3 | Method code, captured while reset is held |
| wr_en | input | 1 | Parallel-load write strobe, active high |
| wr_data | input | OFS_W | Parallel-load data word |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_bit | input | 1 | Serial data bit |
| ofs_y1 | output | OFS_W | First FIFO almost-full offset |
| ofs_x1 | output | OFS_W | First FIFO almost-empty offset |
| ofs_y2 | output | OFS_W | Second FIFO almost-full offset |
| ofs_x2 | output | OFS_W | Second FIFO almost-empty offset |
| prog_done | output | 1 | Offsets are complete and frozen |

## Verification
A corrupted captured method code shows up at the next clock edge after release. The outputs then show the wrong preset, or an immediate `prog_done` appears where a load was expected. A bit counter that is off by one moves `prog_done` one accepted bit early or late, so the bench samples `prog_done` after bit 51 and again after bit 52. A fault in write ordering or in shift direction places the known words into the wrong output, or shifted by one bit. Partial images are therefore compared after each write and after the next-to-last serial bit. Any leak after completion or across methods changes a frozen output at the very next edge, and the bench samples it there.

// File: rtl/flo_pkg.sv
package flo_pkg;

   typedef enum logic [1:0] {
      M_PRESET   = 2'd0,
      M_PARALLEL = 2'd1,
      M_SERIAL   = 2'd2
   } load_mode_e;

   localparam int unsigned SEL_W    = 3;
   localparam int unsigned N_PRESET = 5;
   localparam int unsigned MIN_OFS_W = 11;

   function automatic load_mode_e decode_mode(input logic [SEL_W-1:0] code);
      if (code < SEL_W'(N_PRESET))      return M_PRESET;
      else if (code == SEL_W'(N_PRESET)) return M_PARALLEL;
      else                               return M_SERIAL;
   endfunction

   function automatic int unsigned preset_value(input logic [SEL_W-1:0] code);
      case (code)
         3'd0:    return 8;
         3'd1:    return 16;
         3'd2:    return 64;
         3'd3:    return 256;
         3'd4:    return 1024;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/flo_mode_capture.sv
module flo_mode_capture
   import flo_pkg::*;
(
   input  logic             clk,
   input  logic             mrst_n,
   input  logic [SEL_W-1:0] method_sel,
   output logic [SEL_W-1:0] code_q,
   output load_mode_e       mode
);

   always_ff @(posedge clk) begin
      if (!mrst_n) code_q <= method_sel;
   end

   assign mode = decode_mode(code_q);

   assert_code_held_R2: assert property (@(posedge clk) disable iff (!mrst_n)
      $past(mrst_n) |-> $stable(code_q))
      else $error("method code moved outside reset");

endmodule

// File: rtl/flo_serial_shift.sv
module flo_serial_shift #(
   parameter int unsigned OFS_W = 13
) (
   input  logic               clk,
   input  logic               clear,
   input  logic               active,
   input  logic               ser_en_n,
   input  logic               ser_bit,
   output logic [4*OFS_W-1:0] image,
   output logic               done
);

   localparam int unsigned TOTAL = 4 * OFS_W;
   localparam int unsigned CNT_W = $clog2(TOTAL + 1);

   logic [CNT_W-1:0] taken;
   logic             shift_ok;

   assign shift_ok = active & ~ser_en_n & ~done;

   always_ff @(posedge clk) begin
      if (clear) begin
         image <= '0;
         taken <= '0;
         done  <= 1'b0;
      end else if (shift_ok) begin
         image <= {image[TOTAL-2:0], ser_bit};
         taken <= taken + 1'b1;
         done  <= (taken == CNT_W'(TOTAL - 1));
      end
   end

   assert_count_bound_R6: assert property (@(posedge clk) disable iff (clear)
      taken <= CNT_W'(TOTAL))
      else $error("serial bit count past stream length");

   assert_serial_frozen_R7: assert property (@(posedge clk) disable iff (clear)
      done |=> (done && $stable(image)))
      else $error("serial image changed after completion");

endmodule

// File: rtl/flo_parallel_load.sv
module flo_parallel_load #(
   parameter int unsigned OFS_W = 13
) (
   input  logic               clk,
   input  logic               clear,
   input  logic               active,
   input  logic               wr_en,
   input  logic [OFS_W-1:0]   wr_data,
   output logic [4*OFS_W-1:0] image,
   output logic               done
);

   localparam int unsigned N_SLOT = 4;
   localparam int unsigned IDX_W  = $clog2(N_SLOT);

   logic [IDX_W-1:0] slot_idx;
   logic             take;

   assign take = active & wr_en & ~done;

   for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
      logic [OFS_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (clear) slot_q <= '0;
         else if (take && slot_idx == IDX_W'(g)) slot_q <= wr_data;
      end
      assign image[(N_SLOT-g)*OFS_W-1 -: OFS_W] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (clear) begin
         slot_idx <= '0;
         done     <= 1'b0;
      end else if (take) begin
         slot_idx <= slot_idx + 1'b1;
         done     <= (slot_idx == IDX_W'(N_SLOT - 1));
      end
   end

   assert_write_order_R4: assert property (@(posedge clk) disable iff (clear)
      take |=> (done || slot_idx == $past(slot_idx) + 1'b1))
      else $error("parallel slot order broken");

   assert_parallel_frozen_R7: assert property (@(posedge clk) disable iff (clear)
      done |=> (done && $stable(image)))
      else $error("parallel image changed after completion");

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
   import flo_pkg::*;
#(
   parameter int unsigned OFS_W = 13
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic [2:0]       method_sel,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] wr_data,
   input  logic             ser_en_n,
   input  logic             ser_bit,
   output logic [OFS_W-1:0] ofs_y1,
   output logic [OFS_W-1:0] ofs_x1,
   output logic [OFS_W-1:0] ofs_y2,
   output logic [OFS_W-1:0] ofs_x2,
   output logic             prog_done
);

   localparam int unsigned IMG_W = 4 * OFS_W;

   if (OFS_W < MIN_OFS_W) begin : g_bad_width
      $error("OFS_W too narrow for the largest preset");
   end
   if (OFS_W > 16) begin : g_bad_depth
      $error("OFS_W beyond supported FIFO depth");
   end

   logic [SEL_W-1:0] code_q;
   load_mode_e       mode;
   logic             clear;
   logic [IMG_W-1:0] par_img, ser_img, pre_img, sel_img;
   logic             par_done, ser_done, pre_done;
   logic [OFS_W-1:0] pre_word;

   assign clear = ~mrst_n;

   flo_mode_capture u_mode (
      .clk        (clk),
      .mrst_n     (mrst_n),
      .method_sel (method_sel),
      .code_q     (code_q),
      .mode       (mode)
   );

   flo_parallel_load #(.OFS_W(OFS_W)) u_par (
      .clk     (clk),
      .clear   (clear),
      .active  (mode == M_PARALLEL),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .image   (par_img),
      .done    (par_done)
   );

   flo_serial_shift #(.OFS_W(OFS_W)) u_ser (
      .clk      (clk),
      .clear    (clear),
      .active   (mode == M_SERIAL),
      .ser_en_n (ser_en_n),
      .ser_bit  (ser_bit),
      .image    (ser_img),
      .done     (ser_done)
   );

   always_ff @(posedge clk) begin
      if (clear) pre_done <= 1'b0;
      else if (mode == M_PRESET) pre_done <= 1'b1;
   end

   assign pre_word = pre_done ? OFS_W'(preset_value(code_q)) : '0;
   assign pre_img  = {4{pre_word}};

   always_comb begin
      unique case (mode)
         M_PARALLEL: begin sel_img = par_img; prog_done = par_done; end
         M_SERIAL:   begin sel_img = ser_img; prog_done = ser_done; end
         default:    begin sel_img = pre_img; prog_done = pre_done; end
      endcase
   end

   assign {ofs_y1, ofs_x1, ofs_y2, ofs_x2} = sel_img;

   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!mrst_n)
      prog_done |=> prog_done)
      else $error("done dropped outside reset");

   assert_preset_done_R3: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode == M_PRESET && !prog_done) |=> prog_done)
      else $error("preset not completed in one cycle");

   assert_preset_value_R3: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode == M_PRESET && prog_done) |->
         (ofs_y1 == ofs_x1 && ofs_x1 == ofs_y2 && ofs_y2 == ofs_x2 &&
          $countones(ofs_y1) == 1))
      else $error("preset outputs inconsistent");

endmodule

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;

   localparam int unsigned W = 13;
   localparam int unsigned TOT = 4 * W;

   logic         clk = 1'b0;
   logic         mrst_n = 1'b0;
   logic [2:0]   method_sel = 3'd0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         ser_en_n = 1'b1;
   logic         ser_bit = 1'b0;
   logic [W-1:0] ofs_y1, ofs_x1, ofs_y2, ofs_x2;
   logic         prog_done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   typedef struct {
      logic [4*W-1:0] img;
      logic           done;
      string          tag;
   } exp_t;

   exp_t exp_q[$];
   event chk_ev;

   always #2 clk = ~clk;

   flag_offset_loader #(.OFS_W(W)) dut (
      .clk(clk), .mrst_n(mrst_n), .method_sel(method_sel),
      .wr_en(wr_en), .wr_data(wr_data), .ser_en_n(ser_en_n), .ser_bit(ser_bit),
      .ofs_y1(ofs_y1), .ofs_x1(ofs_x1), .ofs_y2(ofs_y2), .ofs_x2(ofs_x2),
      .prog_done(prog_done)
   );

   // monitor: pops expectations and compares with the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            logic [4*W-1:0] act;
            e = exp_q.pop_front();
            act = {ofs_y1, ofs_x1, ofs_y2, ofs_x2};
            checks++;
            if (act !== e.img || prog_done !== e.done) begin
               errors++;
               $display("FAIL %s: actual img=%h done=%b expected img=%h done=%b",
                        e.tag, act, prog_done, e.img, e.done);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic expect_now(input logic [4*W-1:0] img, input logic d, input string tag);
      exp_t e;
      e.img = img; e.done = d; e.tag = tag;
      exp_q.push_back(e);
      -> chk_ev;
      #0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [2:0] code);
      mrst_n = 1'b0; method_sel = code;
      wr_en = 1'b0; ser_en_n = 1'b1;
      repeat (3) step();
      expect_now('0, 1'b0, "R1 reset clears");
      mrst_n = 1'b1;
   endtask

   task automatic shift_stream(input logic [4*W-1:0] s, input int nbits,
                               inout logic [4*W-1:0] model);
      for (int i = 0; i < nbits; i++) begin
         logic b;
         b = s[TOT-1-i];
         ser_en_n = 1'b0; ser_bit = b; wr_en = 1'b0;
         step();
         model = {model[TOT-2:0], b};
         // idle gap: enable high, bit toggled, write strobe pulsed (R5, R8)
         ser_en_n = 1'b1; ser_bit = ~b; wr_en = 1'b1; wr_data = 13'h1FFF;
         step();
         wr_en = 1'b0;
      end
   endtask

   initial begin
      logic [4*W-1:0] model;
      logic [4*W-1:0] stream;
      logic [W-1:0]   pv [5];
      logic [W-1:0]   pw [4];
      pv[0] = 13'd8; pv[1] = 13'd16; pv[2] = 13'd64; pv[3] = 13'd256; pv[4] = 13'd1024;
      step();

      // R3 presets, R2 select ignored after release
      for (int c = 0; c < 5; c++) begin
         do_reset(3'(c));
         method_sel = 3'd6;
         step();
         expect_now({4{pv[c]}}, 1'b1, "R3 preset load");
         ser_en_n = 1'b0; ser_bit = 1'b1; wr_en = 1'b1;
         step();
         ser_en_n = 1'b1; wr_en = 1'b0;
         expect_now({4{pv[c]}}, 1'b1, "R2 select change ignored");
      end

      // R4 parallel load with serial pulses ignored (R8)
      pw[0] = 13'h0123; pw[1] = 13'h1F0E; pw[2] = 13'h0AA5; pw[3] = 13'h1555;
      do_reset(3'd5);
      method_sel = 3'd7;
      model = '0;
      for (int k = 0; k < 4; k++) begin
         wr_en = 1'b1; wr_data = pw[k];
         step();
         wr_en = 1'b0;
         model[TOT-1-k*W -: W] = pw[k];
         expect_now(model, (k == 3), "R4 parallel write order");
         ser_en_n = 1'b0; ser_bit = 1'b1;
         step();
         ser_en_n = 1'b1;
         expect_now(model, (k == 3), "R8 serial ignored in parallel mode");
      end
      wr_en = 1'b1; wr_data = 13'h0777;
      step();
      wr_en = 1'b0;
      expect_now(model, 1'b1, "R7 write after done ignored");

      // R5/R6 serial load, code 6
      stream = {13'h1234, 13'h0F0F, 13'h1001, 13'h0ABC};
      do_reset(3'd6);
      model = '0;
      shift_stream(stream, TOT - 1, model);
      expect_now(model, 1'b0, "R6 done low before last bit");
      shift_stream(stream << (TOT - 1), 1, model);
      expect_now(stream, 1'b1, "R5 serial image complete");
      shift_stream({TOT{1'b1}}, 3, model);
      expect_now(stream, 1'b1, "R7 serial bits after done ignored");

      // R1 reset mid-load, then code 7 serial
      stream = {13'h1FFE, 13'h0001, 13'h0C3C, 13'h1248};
      do_reset(3'd7);
      model = '0;
      shift_stream(stream, 10, model);
      expect_now(model, 1'b0, "R5 partial stream right aligned");
      do_reset(3'd7);
      model = '0;
      shift_stream(stream, TOT, model);
      expect_now(stream, 1'b1, "R5 code 7 serial complete");
      repeat (2) step();
      expect_now(stream, 1'b1, "R6 done held");

      step();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule